// File: doc/BRIEF.md
# Bidirectional Port Controller with Read-Pulsed Pulldown

This block controls eight general-purpose pins arranged as two groups of four. Each group carries one direction bit and each pin carries one data bit, both held in registers that a CPU writes and reads through a small request/response stream. Three per-pin configuration vectors select how each pin behaves:

- output-only use versus group-controlled direction;
- push-pull drive versus open drain that only drives high;
- whether an internal pulldown is present.

The internal pulldown is not left switched on. A read of a group's data register opens a short window, a fixed number of block clock cycles that stands for half a CPU clock. During that window the pulldown is enabled on that group's undriven pins that have the option. The pin levels are captured on the last cycle of the window. This keeps leakage low while still letting a floating pin settle to a defined level for the read.

Requests enter on a valid/ready channel. The block takes a request only when `req_ready` is high, which is only while it is idle. A read holds `req_ready` low from acceptance until its response has been taken. A response stays on `rsp_valid`/`rsp_data`, unchanged, until `rsp_ready` is seen high at a clock edge. Writes complete in the cycle they are accepted and produce no response.

Top module: `pulsed_pd_port`

## Requirements
- R1: After reset both direction bits and all data bits are 0, `pin_pd` is 0, `rsp_valid` is 0, `req_ready` is 1, and only push-pull output-only pins have `pin_oe` set.
- R2: Direction bit 1 makes every pin of its group drive and 0 makes it an input; the two groups act independently.
- R3: A pin configured output-only drives whatever its group's direction bit is.
- R4: `pin_out` always equals the pin's data bit, and a driving push-pull pin has `pin_oe` set.
- R5: A driving open-drain pin asserts `pin_oe` only while its data bit is 1, so it never actively drives low.
- R6: A data-register read enables the pulldown for exactly PD_CYCLES consecutive cycles, starting in the cycle after acceptance, only on the addressed group, and at no other time.
- R7: A pin without the pulldown option, or a pin that is driving, never has `pin_pd` set.
- R8: Data-read response bit i returns the data bit for a driving pin and, for an input pin, the `pin_in` level captured at the clock edge that ends the pulldown window.
- R9: `rsp_valid` and `rsp_data` are held stable until `rsp_ready` is 1 at a clock edge, and `req_ready` stays 0 while a read is in flight.
- R10: A direction read returns the direction bit in response bit 0 with the other bits 0, and opens no pulldown window.
- R11: `req_addr` bit 1 selects direction (1) or data (0), and bit 0 selects the group. A write changes only the addressed register, visible the cycle after acceptance. A direction write uses `req_wdata` bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_out_only | input | 8 | Per pin: 1 = output-only |
| cfg_open_drain | input | 8 | Per pin: 1 = high-side open drain, 0 = push-pull |
| cfg_pulldown | input | 8 | Per pin: 1 = internal pulldown present |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 2 | Bit 1: 1 = direction, 0 = data; bit 0: group |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Response consumer ready |
| rsp_data | output | 4 | Read response data |
| pin_in | input | 8 | Pin levels seen at the pads |
| pin_out | output | 8 | Per-pin drive value |
| pin_oe | output | 8 | Per-pin drive enable |
| pin_pd | output | 8 | Per-pin pulldown enable |

## Verification
A wrong direction bit or data bit shows on `pin_oe` and `pin_out` in the cycle after the write that should have set it, well before any read. A window counter that is off by one, or a group select that is wrong, shows as a pulldown run of the wrong length or on the wrong pins. It also shows in the response, which then carries pin levels from the wrong cycle. A state machine that leaves its response state early or late shows up as a dropped or changed response while `rsp_ready` is held low, or as a request accepted while a read is still pending.

// File: rtl/gpp_pkg.sv
package gpp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PULL = 2'd1,
    ST_RESP = 2'd2
  } rd_state_e;

  // select width for a group index, at least one bit
  function automatic int sel_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/gpp_regs.sv
module gpp_regs #(
  parameter int NGRP   = 2,
  parameter int GW     = 4,
  parameter int GSEL_W = 1,
  localparam int NPIN  = NGRP * GW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              wr_is_dir,
  input  logic [GSEL_W-1:0] wr_grp,
  input  logic [GW-1:0]     wr_data,
  output logic [NPIN-1:0]   data_q,
  output logic [NGRP-1:0]   dir_q
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (wr_grp == GSEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dir_q[g]             <= 1'b0;
        data_q[g*GW +: GW]   <= '0;
      end else if (hit) begin
        if (wr_is_dir) dir_q[g]           <= wr_data[0];
        else           data_q[g*GW +: GW] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/gpp_pin_cell.sv
module gpp_pin_cell (
  input  logic out_only,
  input  logic open_drain,
  input  logic has_pd,
  input  logic dir,
  input  logic data,
  input  logic pd_win,
  input  logic pin_in,
  output logic drive_val,
  output logic drive_en,
  output logic pd_en,
  output logic rd_bit
);
  logic active;

  assign active    = out_only | dir;
  assign drive_val = data;
  // open drain only sources current when the data bit is high
  assign drive_en  = active & (~open_drain | data);
  assign pd_en     = pd_win & has_pd & ~active;
  assign rd_bit    = active ? data : pin_in;
endmodule

// File: rtl/gpp_read_seq.sv
module gpp_read_seq
  import gpp_pkg::*;
#(
  parameter int NGRP      = 2,
  parameter int GW        = 4,
  parameter int GSEL_W    = 1,
  parameter int PD_CYCLES = 2,
  localparam int NPIN     = NGRP * GW,
  localparam int CNT_W    = $clog2(PD_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_is_dir,
  input  logic [GSEL_W-1:0] req_grp,
  output logic              req_ready,
  output logic              wr_en,
  input  logic [NPIN-1:0]   rd_bits,
  input  logic [NGRP-1:0]   dir_all,
  output logic              win_on,
  output logic [GSEL_W-1:0] win_grp,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [GW-1:0]     rsp_data
);
  rd_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [GSEL_W-1:0] grp_q;
  logic [GW-1:0]     rsp_q;
  logic [GW-1:0]     dir_word;
  logic [GW-1:0]     grp_bits;
  logic              accept;

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid & req_ready;
  assign wr_en     = accept & req_write;
  assign win_on    = (state == ST_PULL);
  assign win_grp   = grp_q;
  assign rsp_valid = (state == ST_RESP);
  assign rsp_data  = rsp_q;
  assign grp_bits  = rd_bits[grp_q*GW +: GW];

  always_comb begin
    dir_word    = '0;
    dir_word[0] = dir_all[req_grp];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
      grp_q <= '0;
      rsp_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (accept && !req_write) begin
            grp_q <= req_grp;
            if (req_is_dir) begin
              rsp_q <= dir_word;
              state <= ST_RESP;
            end else begin
              cnt   <= CNT_W'(PD_CYCLES - 1);
              state <= ST_PULL;
            end
          end
        end
        ST_PULL: begin
          if (cnt == '0) begin
            rsp_q <= grp_bits;
            state <= ST_RESP;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pulsed_pd_port.sv
module pulsed_pd_port
  import gpp_pkg::*;
#(
  parameter int NGRP      = 2,
  parameter int GW        = 4,
  parameter int PD_CYCLES = 2,
  localparam int NPIN     = NGRP * GW,
  localparam int GSEL_W   = sel_width(NGRP),
  localparam int AW       = GSEL_W + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] cfg_out_only,
  input  logic [NPIN-1:0] cfg_open_drain,
  input  logic [NPIN-1:0] cfg_pulldown,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic            req_write,
  input  logic [AW-1:0]   req_addr,
  input  logic [GW-1:0]   req_wdata,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [GW-1:0]   rsp_data,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic [NPIN-1:0] pin_pd
);
  logic              wr_en;
  logic              req_is_dir;
  logic [GSEL_W-1:0] req_grp;
  logic [NPIN-1:0]   data_q;
  logic [NGRP-1:0]   dir_q;
  logic [NPIN-1:0]   rd_bits;
  logic              win_on;
  logic [GSEL_W-1:0] win_grp;

  assign req_is_dir = req_addr[AW-1];
  assign req_grp    = req_addr[GSEL_W-1:0];

  gpp_regs #(.NGRP(NGRP), .GW(GW), .GSEL_W(GSEL_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_is_dir (req_is_dir),
    .wr_grp    (req_grp),
    .wr_data   (req_wdata),
    .data_q    (data_q),
    .dir_q     (dir_q)
  );

  gpp_read_seq #(.NGRP(NGRP), .GW(GW), .GSEL_W(GSEL_W), .PD_CYCLES(PD_CYCLES)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_is_dir (req_is_dir),
    .req_grp    (req_grp),
    .req_ready  (req_ready),
    .wr_en      (wr_en),
    .rd_bits    (rd_bits),
    .dir_all    (dir_q),
    .win_on     (win_on),
    .win_grp    (win_grp),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_data   (rsp_data)
  );

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    logic grp_win;
    assign grp_win = win_on && (win_grp == GSEL_W'(g));

    for (genvar i = 0; i < GW; i++) begin : g_pin
      localparam int P = g * GW + i;
      gpp_pin_cell u_cell (
        .out_only   (cfg_out_only[P]),
        .open_drain (cfg_open_drain[P]),
        .has_pd     (cfg_pulldown[P]),
        .dir        (dir_q[g]),
        .data       (data_q[P]),
        .pd_win     (grp_win),
        .pin_in     (pin_in[P]),
        .drive_val  (pin_out[P]),
        .drive_en   (pin_oe[P]),
        .pd_en      (pin_pd[P]),
        .rd_bit     (rd_bits[P])
      );
    end
  end
endmodule

// File: rtl/pulsed_pd_port_chk.sv
module pulsed_pd_port_chk #(
  parameter int NPIN      = 8,
  parameter int GW        = 4,
  parameter int PD_CYCLES = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NPIN-1:0] cfg_out_only,
  input logic [NPIN-1:0] cfg_open_drain,
  input logic [NPIN-1:0] cfg_pulldown,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [GW-1:0]   rsp_data,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic [NPIN-1:0] pin_pd
);
  int run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run_len <= 0;
    else if (|pin_pd) run_len <= run_len + 1;
    else              run_len <= 0;
  end

  a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  a_r6_pd_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (|pin_pd) |-> (!req_ready && !rsp_valid));

  a_r6_window_len: assert property (@(posedge clk) disable iff (!rst_n)
    (run_len != 0 && !(|pin_pd)) |-> run_len == PD_CYCLES);

  a_r6_window_max: assert property (@(posedge clk) disable iff (!rst_n)
    run_len <= PD_CYCLES);

  a_r7_pd_option: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pd & ~cfg_pulldown) == '0);

  a_r7_pd_vs_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_pd & pin_oe) == '0);

  a_r5_od_high_only: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & cfg_open_drain & ~pin_out) == '0);

  a_r3_outonly_drives: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_out_only & ~cfg_open_drain & ~pin_oe) == '0);
endmodule

bind pulsed_pd_port pulsed_pd_port_chk #(.NPIN(NPIN), .GW(GW), .PD_CYCLES(PD_CYCLES)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .cfg_out_only   (cfg_out_only),
  .cfg_open_drain (cfg_open_drain),
  .cfg_pulldown   (cfg_pulldown),
  .req_ready      (req_ready),
  .rsp_valid      (rsp_valid),
  .rsp_ready      (rsp_ready),
  .rsp_data       (rsp_data),
  .pin_out        (pin_out),
  .pin_oe         (pin_oe),
  .pin_pd         (pin_pd)
);

// File: tb/sim_pulsed_pd_port.sv
module sim_pulsed_pd_port;
  localparam int NGRP = 2;
  localparam int GW   = 4;
  localparam int NPIN = 8;
  localparam int PDC  = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n;
  logic [NPIN-1:0] cfg_out_only, cfg_open_drain, cfg_pulldown;
  logic            req_valid, req_ready, req_write;
  logic [1:0]      req_addr;
  logic [GW-1:0]   req_wdata;
  logic            rsp_valid, rsp_ready;
  logic [GW-1:0]   rsp_data;
  logic [NPIN-1:0] pin_in, pin_out, pin_oe, pin_pd;

  pulsed_pd_port #(.NGRP(NGRP), .GW(GW), .PD_CYCLES(PDC)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cfg_out_only(cfg_out_only), .cfg_open_drain(cfg_open_drain), .cfg_pulldown(cfg_pulldown),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe), .pin_pd(pin_pd)
  );

  logic [NPIN-1:0] m_data;
  logic [NGRP-1:0] m_dir;
  logic [GW-1:0]   exp_q[$];
  string           tag_q[$];
  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [NPIN-1:0] m_active();
    logic [NPIN-1:0] a;
    for (int i = 0; i < NPIN; i++) a[i] = cfg_out_only[i] | m_dir[i/GW];
    return a;
  endfunction

  function automatic logic [NPIN-1:0] m_oe();
    return m_active() & (~cfg_open_drain | m_data);
  endfunction

  function automatic logic [GW-1:0] m_rd(input int g, input logic [NPIN-1:0] pins);
    logic [GW-1:0] r;
    logic [NPIN-1:0] a;
    a = m_active();
    for (int i = 0; i < GW; i++) r[i] = a[g*GW+i] ? m_data[g*GW+i] : pins[g*GW+i];
    return r;
  endfunction

  function automatic logic [NPIN-1:0] m_pd(input int g);
    logic [NPIN-1:0] gm;
    gm = '0;
    for (int i = 0; i < GW; i++) gm[g*GW+i] = 1'b1;
    return cfg_pulldown & ~m_active() & gm;
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected response", 1, 0);
      end else begin
        logic [GW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rsp_data, e);
      end
    end
  end

  task automatic bus_req(input logic wr, input logic [1:0] addr, input logic [GW-1:0] wd);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
  endtask

  task automatic bus_write(input logic [1:0] addr, input logic [GW-1:0] wd);
    bus_req(1'b1, addr, wd);
    if (addr[1]) m_dir[addr[0]] = wd[0];
    else         m_data[addr[0]*GW +: GW] = wd;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [1:0] addr, input logic [GW-1:0] exp, input string tag,
                         input logic [NPIN-1:0] pd_exp, input bit use_late,
                         input logic [NPIN-1:0] late_pins, output int pd_cyc, output int pd_bad);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    bus_req(1'b0, addr, '0);
    pd_cyc = 0; pd_bad = 0;
    do begin
      @(negedge clk);
      req_valid = 1'b0;
      if (pin_pd != '0) begin
        pd_cyc++;
        if (pin_pd !== pd_exp) pd_bad++;
        if (use_late && pd_cyc == PDC) pin_in = late_pins;
      end
    end while (exp_q.size() != 0);
  endtask

  task automatic chk_pins(input string tag);
    check({tag, " pin_oe"}, 32'(pin_oe), 32'(m_oe()));
    check({tag, " pin_out"}, 32'(pin_out), 32'(m_data));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int pc, pb;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    rsp_ready = 1'b1; pin_in = '0;
    cfg_out_only = 8'h01; cfg_open_drain = 8'h30; cfg_pulldown = 8'hEE;
    m_data = '0; m_dir = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 reset pin_oe", 32'(pin_oe), 32'h01);
    check("R1 reset pin_out", 32'(pin_out), 0);
    check("R1 reset pin_pd", 32'(pin_pd), 0);
    check("R1 reset rsp_valid", 32'(rsp_valid), 0);
    check("R1 reset req_ready", 32'(req_ready), 1);

    // R8 / R6 read group 0 inputs
    pin_in = 8'hA6;
    do_read(2'b00, m_rd(0, pin_in), "R8 read g0 inputs", m_pd(0), 0, '0, pc, pb);
    check("R6 window length g0", pc, PDC);
    check("R6 R7 pulldown pins g0", pb, 0);
    check("R6 pulldown off after read", 32'(pin_pd), 0);

    // R11 data write with input direction, then R2 direction write
    bus_write(2'b01, 4'b0101);
    chk_pins("R11 data write g1");
    bus_write(2'b11, 4'b0001);
    chk_pins("R2 R4 R5 g1 output");
    check("R5 od pin5 low not driven", 32'(pin_oe[5]), 0);

    // R7 read of driving group: no pulldown
    do_read(2'b01, m_rd(1, pin_in), "R8 read g1 register", m_pd(1), 0, '0, pc, pb);
    check("R7 no pulldown on driving pins", pc, 0);

    // R3 out-only pin drives while group is input
    bus_write(2'b00, 4'b1111);
    chk_pins("R3 out-only drives");
    check("R3 pin0 oe", 32'(pin_oe[0]), 1);

    // R8 capture at end of window
    pin_in = 8'h00;
    do_read(2'b00, m_rd(0, 8'h0A), "R8 late sample", m_pd(0), 1, 8'h0A, pc, pb);
    check("R6 window length late", pc, PDC);

    // R10 direction reads
    do_read(2'b10, 4'b0000, "R10 dir g0", '0, 0, '0, pc, pb);
    check("R10 no window dir g0", pc, 0);
    do_read(2'b11, 4'b0001, "R10 dir g1", '0, 0, '0, pc, pb);
    check("R10 no window dir g1", pc, 0);

    // R9 back-pressure
    rsp_ready = 1'b0;
    exp_q.push_back(m_rd(1, pin_in));
    tag_q.push_back("R9 held response");
    bus_req(1'b0, 2'b01, '0);
    @(negedge clk);
    req_valid = 1'b0;
    repeat (PDC + 3) @(negedge clk);
    check("R9 rsp_valid held", 32'(rsp_valid), 1);
    check("R9 req_ready low", 32'(req_ready), 0);
    check("R9 rsp_data held", 32'(rsp_data), 32'(m_rd(1, pin_in)));
    rsp_ready = 1'b1;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    check("R9 ready after response", 32'(req_ready), 1);

    // R2 group back to input
    bus_write(2'b11, 4'b0000);
    chk_pins("R2 g1 input again");

    // R3 R5 open-drain out-only pin
    cfg_out_only = 8'h11;
    @(negedge clk);
    chk_pins("R3 R5 od out-only");

    // R7 group 0 output: read returns register, no pulldown
    bus_write(2'b10, 4'b0001);
    chk_pins("R2 g0 output");
    pin_in = 8'h00;
    do_read(2'b00, 4'hF, "R8 read g0 register", m_pd(0), 0, '0, pc, pb);
    check("R7 no pulldown g0 output", pc, 0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule